// File: doc/BRIEF.md
# Quad Low-Side Switch Control Core

This block is the digital decision core of a four-channel low-side power switch. Each channel has a logic input, an "input is floating" flag and a 9-bit junction temperature code in whole degrees Celsius. From these the core produces one gate-on command per channel and a single open-drain diagnostic pull-down command. A global enable puts the whole switch to sleep or wakes it. A polarity input picks whether a low or a high channel input turns the switch on, and it also flips the sense of the diagnostic.

All timing runs on one free-running clock. The wake-up settling window, the turn-on delay, the turn-off delay and the diagnostic reporting delay are parameters counted in clock ticks. Each channel has its own over-temperature latch with hysteresis and restarts by itself. A ground-or-supply-loss flag is accepted as a global fault that affects the diagnostic only. Floating enable and polarity pins are flagged by their own inputs and are then read as low.

Top module: `lsd_quad_ctrl`

## Requirements
- R1: While the effective enable is low, every gate command and the diagnostic pull-down are low from the next clock edge on, whatever the other inputs are.
- R2: With polarity low (polarity_i=0, direct mode), a settled and healthy channel is commanded on when its input is 0 and off when its input is 1.
- R3: With polarity high (polarity_i=1, inverted mode), a settled and healthy channel is commanded on when its input is 1 and off when its input is 0.
- R4: A channel whose chan_open_i bit is 1 is commanded off in either polarity, and its gate never turns on while the flag stays set.
- R5: en_open_i=1 makes the enable read as 0, and pol_open_i=1 makes the polarity read as 0 (direct mode), whatever en_i and polarity_i carry.
- R6: A channel latches thermal shutdown at the clock edge after its temperature code is at or above TRIP_C (default 175) and is forced off. It leaves shutdown only at the edge after its code is at or below TRIP_C-HYST_K (default 155); between the two levels the state holds.
- R7: In direct mode the diagnostic pull-down is on while no channel is in shutdown and ground_loss_i=0. It is released when any channel is in shutdown or when ground_loss_i=1.
- R8: In inverted mode the diagnostic pull-down is released in normal operation and turned on when any channel is in shutdown or ground_loss_i=1.
- R9: After the effective enable rises, every gate stays off for SETTLE_TICKS clock edges; the channel request takes effect from the following edge.
- R10: A gate turns on only after its on-request has persisted for ON_TICKS consecutive edges, and turns off only after its off-request has persisted for OFF_TICKS edges. A shorter request leaves the gate unchanged.
- R11: The diagnostic pull-down takes a new value only after the new value has been requested for DIAG_TICKS consecutive edges. A shorter fault pulse is not reported.
- R12: A synchronous active-low reset clears all shutdown latches and counters, holds every gate off and releases the diagnostic pull-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Global enable (1 = awake) |
| en_open_i | input | 1 | Enable pin is floating |
| polarity_i | input | 1 | 0 = direct (input low turns on), 1 = inverted |
| pol_open_i | input | 1 | Polarity pin is floating |
| chan_in_i | input | NCH | Per-channel logic input |
| chan_open_i | input | NCH | Per-channel input-floating flag |
| ground_loss_i | input | 1 | Ground or supply loss detected |
| temp_i | input | NCH*TW | Junction temperature codes, channel k at bits [k*TW +: TW] |
| gate_on_o | output | NCH | Gate-on command per channel |
| diag_pull_o | output | 1 | Diagnostic open-drain pull-down command |

## Verification
Channel input patterns such as 0101, 0011 and 0000 are applied in both polarities. A wrong polarity decode shows as a mirror-image gate pattern, and a channel mix-up shows as a shifted one. Temperature codes are stepped through the trip level, a value inside the hysteresis band and the resume level. This separates a missing hysteresis from a wrong threshold, and the same steps also exercise both diagnostic senses. Pulses shorter than the on, off and diagnostic delays are applied next to pulses that last long enough, so an off-by-one delay or a delay that does not restart is exposed. Each floating-pin flag, a sleep entry and a mid-run reset are also applied.

// File: rtl/lsd_pkg.sv
// Shared types and helpers for the quad low-side switch control core.
// Assumes: one bit per channel input, polarity encoded as a single bit.
package lsd_pkg;

    // Transfer polarity selected by the programming input.
    typedef enum logic {
        POL_DIRECT = 1'b0,  // input low commands the switch on
        POL_INVERT = 1'b1   // input high commands the switch on
    } pol_e;

    // Raw on-request of one channel before settling, open and thermal gating.
    function automatic logic wants_on(input logic level, input pol_e pol);
        return (pol == POL_INVERT) ? level : ~level;
    endfunction

endpackage

// File: rtl/lsd_thermal_guard.sv
// Per-channel over-temperature latch with hysteresis.
// Sets when the code reaches TRIP, clears when the code drops to TRIP-HYST
// or below, and holds in between. Assumes TRIP > HYST and that codes are
// unsigned whole degrees, with one registered comparison per clock.
module lsd_thermal_guard #(
    parameter int unsigned TW   = 9,
    parameter int unsigned TRIP = 175,
    parameter int unsigned HYST = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] temp_i,
    output logic          hot_o
);
    localparam logic [TW-1:0] TRIP_CODE   = TW'(TRIP);
    localparam logic [TW-1:0] RESUME_CODE = TW'(TRIP - HYST);

    logic hot_q;

    // Latch or release the shutdown state from the current temperature code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hot_q <= 1'b0;
        end else if (temp_i >= TRIP_CODE) begin
            hot_q <= 1'b1;
        end else if (temp_i <= RESUME_CODE) begin
            hot_q <= 1'b0;
        end
    end

    assign hot_o = hot_q;

    // R6
    trip_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (temp_i >= TRIP_CODE) |=> hot_q);

    // R6
    band_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hot_q && temp_i > RESUME_CODE) |=> hot_q);

    // R6
    cold_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hot_q && temp_i < TRIP_CODE) |=> !hot_q);

endmodule

// File: rtl/lsd_edge_delay.sv
// Asymmetric persistence filter. The output takes the requested level only
// after the request has differed from it for RISE_TICKS (0->1) or
// FALL_TICKS (1->0) consecutive edges. force_low_i clears the output at the
// next edge with no delay. Assumes both tick counts are at least 1.
module lsd_edge_delay #(
    parameter int unsigned RISE_TICKS = 300,
    parameter int unsigned FALL_TICKS = 300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic force_low_i,
    input  logic req_i,
    output logic out_o
);
    localparam int unsigned MAX_T = (RISE_TICKS > FALL_TICKS) ? RISE_TICKS : FALL_TICKS;
    localparam int unsigned CW    = (MAX_T < 2) ? 1 : $clog2(MAX_T + 1);
    localparam logic [CW-1:0] RISE_LAST = CW'(RISE_TICKS - 1);
    localparam logic [CW-1:0] FALL_LAST = CW'(FALL_TICKS - 1);

    logic          out_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last;

    // Pick the persistence limit for the transition that would happen next.
    always_comb begin
        last = out_q ? FALL_LAST : RISE_LAST;
    end

    // Count the mismatch and flip the output when it has lasted long enough.
    always_ff @(posedge clk) begin
        if (!rst_n || force_low_i) begin
            out_q <= 1'b0;
            cnt_q <= '0;
        end else if (req_i == out_q) begin
            cnt_q <= '0;
        end else if (cnt_q == last) begin
            out_q <= req_i;
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign out_o = out_q;

    // R10
    rise_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_q) |-> $past(req_i));

    // R10
    match_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!force_low_i && req_i == out_q) |=> $stable(out_q));

    // R10
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(MAX_T - 1));

endmodule

// File: rtl/lsd_quad_ctrl.sv
// Control core of a multi-channel low-side switch.
// Resolves floating enable/polarity pins to low, times the wake-up settling
// window, gates each channel request by polarity, open-input and thermal
// state, delays gate edges, and drives the diagnostic pull-down whose sense
// follows the polarity. Assumes all inputs are synchronous to clk.
module lsd_quad_ctrl
    import lsd_pkg::*;
#(
    parameter int unsigned NCH          = 4,
    parameter int unsigned TW           = 9,
    parameter int unsigned TRIP_C       = 175,
    parameter int unsigned HYST_K       = 20,
    parameter int unsigned SETTLE_TICKS = 2000,
    parameter int unsigned ON_TICKS     = 300,
    parameter int unsigned OFF_TICKS    = 300,
    parameter int unsigned DIAG_TICKS   = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              en_open_i,
    input  logic              polarity_i,
    input  logic              pol_open_i,
    input  logic [NCH-1:0]    chan_in_i,
    input  logic [NCH-1:0]    chan_open_i,
    input  logic              ground_loss_i,
    input  logic [NCH*TW-1:0] temp_i,
    output logic [NCH-1:0]    gate_on_o,
    output logic              diag_pull_o
);
    localparam int unsigned SW = (SETTLE_TICKS < 2) ? 1 : $clog2(SETTLE_TICKS + 1);
    localparam logic [SW-1:0] SETTLE_END = SW'(SETTLE_TICKS);

    logic           en_eff;
    pol_e           pol_eff;
    logic [SW-1:0]  settle_q;
    logic           ready;
    logic [NCH-1:0] hot;
    logic [NCH-1:0] req;
    logic           fault;
    logic           diag_req;

    // Resolve floating control pins to their forced low level.
    always_comb begin
        en_eff  = en_i & ~en_open_i;
        pol_eff = pol_e'(polarity_i & ~pol_open_i);
    end

    // Count edges since wake-up, saturating at the settling length.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_eff) begin
            settle_q <= '0;
        end else if (settle_q != SETTLE_END) begin
            settle_q <= settle_q + 1'b1;
        end
    end

    assign ready = (settle_q == SETTLE_END);

    generate
        for (genvar k = 0; k < NCH; k++) begin : g_chan
            // Per-channel thermal latch.
            lsd_thermal_guard #(
                .TW   (TW),
                .TRIP (TRIP_C),
                .HYST (HYST_K)
            ) u_therm (
                .clk    (clk),
                .rst_n  (rst_n),
                .temp_i (temp_i[k*TW +: TW]),
                .hot_o  (hot[k])
            );

            // Combine polarity, settling, open input and thermal state.
            always_comb begin
                req[k] = ready & ~chan_open_i[k] & ~hot[k]
                       & wants_on(chan_in_i[k], pol_eff);
            end

            // Per-channel on/off propagation delay.
            lsd_edge_delay #(
                .RISE_TICKS (ON_TICKS),
                .FALL_TICKS (OFF_TICKS)
            ) u_gate (
                .clk         (clk),
                .rst_n       (rst_n),
                .force_low_i (~en_eff),
                .req_i       (req[k]),
                .out_o       (gate_on_o[k])
            );

            // R4
            open_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (chan_open_i[k] && !gate_on_o[k]) |=> !gate_on_o[k]);

            // R6
            hot_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (hot[k] && !gate_on_o[k]) |=> !gate_on_o[k]);
        end
    endgenerate

    // Build the requested diagnostic level from the global fault and polarity.
    always_comb begin
        fault    = (|hot) | ground_loss_i;
        diag_req = en_eff & ((pol_eff == POL_INVERT) ? fault : ~fault);
    end

    // Diagnostic reporting delay, symmetric in both directions.
    lsd_edge_delay #(
        .RISE_TICKS (DIAG_TICKS),
        .FALL_TICKS (DIAG_TICKS)
    ) u_diag (
        .clk         (clk),
        .rst_n       (rst_n),
        .force_low_i (~en_eff),
        .req_i       (diag_req),
        .out_o       (diag_pull_o)
    );

    // R1
    sleep_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_eff |=> (gate_on_o == '0 && !diag_pull_o));

    // R9
    settle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && gate_on_o == '0) |=> (gate_on_o == '0));

    // R11
    diag_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_eff && diag_req == diag_pull_o) |=> $stable(diag_pull_o));

endmodule

// File: tb/lsd_quad_ctrl_tb_top.sv
// Bench for lsd_quad_ctrl: a behavioural reference model is stepped on every
// rising edge and compared with the outputs on every falling edge; directed
// checks confirm settled values at the end of each phase.
module lsd_quad_ctrl_tb_top;
    localparam int NCH = 4;
    localparam int TW  = 9;
    localparam int SET = 12;
    localparam int TON = 3;
    localparam int TOF = 5;
    localparam int TDG = 6;
    localparam int TRIP = 175;
    localparam int HYST = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, en_open = 1'b0, pol = 1'b0, pol_open = 1'b0, gnd_loss = 1'b0;
    logic [NCH-1:0] ch_in = '0, ch_open = '0;
    logic [NCH*TW-1:0] temps = '0;
    logic [NCH-1:0] gate;
    logic diag;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    string phase = "R12";

    always #5 clk = ~clk;

    lsd_quad_ctrl #(
        .NCH(NCH), .TW(TW), .TRIP_C(TRIP), .HYST_K(HYST),
        .SETTLE_TICKS(SET), .ON_TICKS(TON), .OFF_TICKS(TOF), .DIAG_TICKS(TDG)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .en_i(en), .en_open_i(en_open),
        .polarity_i(pol), .pol_open_i(pol_open), .chan_in_i(ch_in),
        .chan_open_i(ch_open), .ground_loss_i(gnd_loss), .temp_i(temps),
        .gate_on_o(gate), .diag_pull_o(diag)
    );

    // Reference model state.
    int m_settle = 0;
    bit m_hot[NCH];
    bit m_gate[NCH];
    int m_gcnt[NCH];
    bit m_diag = 0;
    int m_dcnt = 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    function automatic int model_gates();
        int v = 0;
        for (int i = 0; i < NCH; i++) v |= (m_gate[i] ? 1 : 0) << i;
        return v;
    endfunction

    // Step the reference model at each rising edge.
    always @(posedge clk) begin
        bit e, p, rdy, flt, dreq;
        bit rq[NCH];
        int t;
        cycles++;
        if (!rst_n) begin
            m_settle = 0; m_diag = 0; m_dcnt = 0;
            for (int i = 0; i < NCH; i++) begin
                m_hot[i] = 0; m_gate[i] = 0; m_gcnt[i] = 0;
            end
        end else begin
            e = en && !en_open;
            p = pol && !pol_open;
            rdy = (m_settle >= SET);
            flt = gnd_loss;
            for (int i = 0; i < NCH; i++) flt |= m_hot[i];
            for (int i = 0; i < NCH; i++)
                rq[i] = rdy && !ch_open[i] && !m_hot[i] && (ch_in[i] == p);
            dreq = e && (p ? flt : !flt);
            if (!e) m_settle = 0; else if (m_settle < SET) m_settle++;
            for (int i = 0; i < NCH; i++) begin
                t = int'(temps[i*TW +: TW]);
                if (t >= TRIP) m_hot[i] = 1; else if (t <= TRIP - HYST) m_hot[i] = 0;
                if (!e) begin m_gate[i] = 0; m_gcnt[i] = 0; end
                else if (rq[i] == m_gate[i]) m_gcnt[i] = 0;
                else if (m_gcnt[i] + 1 >= (m_gate[i] ? TOF : TON)) begin
                    m_gate[i] = rq[i]; m_gcnt[i] = 0;
                end else m_gcnt[i]++;
            end
            if (!e) begin m_diag = 0; m_dcnt = 0; end
            else if (dreq == m_diag) m_dcnt = 0;
            else if (m_dcnt + 1 >= TDG) begin m_diag = dreq; m_dcnt = 0; end
            else m_dcnt++;
        end
    end

    // Compare outputs with the model away from the active edge.
    always @(negedge clk) begin
        chk({phase, " gates vs model"}, int'(gate), model_gates());
        chk({phase, " diag vs model"}, int'(diag), int'(m_diag));
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_temp(input int ch, input int t);
        temps[ch*TW +: TW] = TW'(t);
    endtask

    initial begin
        for (int i = 0; i < NCH; i++) set_temp(i, 25);
        // R12: reset state
        wait_cyc(3);
        chk("R12 reset gates", int'(gate), 0);
        chk("R12 reset diag", int'(diag), 0);
        rst_n = 1'b1;

        // R9 settling then R2 direct mode
        phase = "R9"; en = 1'b1; ch_in = 4'b0101;
        wait_cyc(SET);
        chk("R9 gates off inside settling", int'(gate), 0);
        wait_cyc(TON + 1);
        chk("R2 direct 0101", int'(gate), 4'b1010);
        phase = "R7"; wait_cyc(TDG + 2);
        chk("R7 diag on in normal direct", int'(diag), 1);

        // R10 input change and short pulses
        phase = "R2"; ch_in = 4'b0011; wait_cyc(TOF + 3);
        chk("R2 direct 0011", int'(gate), 4'b1100);
        phase = "R10"; ch_in = 4'b0010; wait_cyc(TON - 1); ch_in = 4'b0011; wait_cyc(4);
        chk("R10 short on-request ignored", int'(gate), 4'b1100);
        ch_in = 4'b0111; wait_cyc(TOF - 1); ch_in = 4'b0011; wait_cyc(4);
        chk("R10 short off-request ignored", int'(gate), 4'b1100);

        // R3 inverted mode and R8 diag sense
        phase = "R3"; pol = 1'b1; wait_cyc(TOF + TDG + 3);
        chk("R3 inverted 0011", int'(gate), 4'b0011);
        chk("R8 diag released in normal inverted", int'(diag), 0);

        // R4 open channel input
        phase = "R4"; ch_open = 4'b0001; wait_cyc(TOF + 2);
        chk("R4 open input forces off", int'(gate), 4'b0010);
        ch_open = 4'b0000; wait_cyc(TON + 2);

        // R6 thermal with hysteresis, inverted diag
        phase = "R6"; set_temp(1, 175); wait_cyc(TOF + TDG + 3);
        chk("R6 trip shuts channel 1", int'(gate), 4'b0001);
        chk("R8 diag on at shutdown", int'(diag), 1);
        set_temp(1, 160); wait_cyc(TON + 4);
        chk("R6 band holds shutdown", int'(gate), 4'b0001);
        set_temp(1, 155); wait_cyc(TON + TDG + 3);
        chk("R6 resume at trip minus hysteresis", int'(gate), 4'b0011);
        chk("R8 diag released after resume", int'(diag), 0);

        // R7 direct diag with thermal and ground loss
        phase = "R7"; pol = 1'b0; ch_in = 4'b0000; wait_cyc(TOF + TON + TDG + 3);
        chk("R2 direct 0000", int'(gate), 4'b1111);
        set_temp(3, 200); wait_cyc(TOF + TDG + 3);
        chk("R7 diag released at shutdown", int'(diag), 0);
        chk("R6 channel 3 off", int'(gate), 4'b0111);
        set_temp(3, 25); wait_cyc(TON + TDG + 3);
        gnd_loss = 1'b1; wait_cyc(TDG + 2);
        chk("R7 diag released on ground loss", int'(diag), 0);
        chk("R7 gates unaffected by ground loss", int'(gate), 4'b1111);
        gnd_loss = 1'b0; wait_cyc(TDG + 2);
        phase = "R11"; gnd_loss = 1'b1; wait_cyc(TDG - 1); gnd_loss = 1'b0; wait_cyc(3);
        chk("R11 short fault not reported", int'(diag), 1);

        // R5 floating pins
        phase = "R5"; pol = 1'b1; pol_open = 1'b1; wait_cyc(TOF + 3);
        chk("R5 open polarity reads direct", int'(gate), 4'b1111);
        en_open = 1'b1; wait_cyc(2);
        chk("R5 open enable sleeps gates", int'(gate), 0);
        chk("R5 open enable sleeps diag", int'(diag), 0);
        en_open = 1'b0; pol_open = 1'b0; pol = 1'b0;
        wait_cyc(SET + TON + TDG + 3);

        // R1 sleep takes effect at the next edge
        phase = "R1"; en = 1'b0; wait_cyc(1);
        chk("R1 sleep gates", int'(gate), 0);
        chk("R1 sleep diag", int'(diag), 0);
        ch_in = 4'b1010; set_temp(0, 250); wait_cyc(5);
        chk("R1 sleep ignores inputs", int'(gate), 0);
        set_temp(0, 25); en = 1'b1; wait_cyc(SET + TON + 2);

        // R12 reset in mid-operation
        phase = "R12"; rst_n = 1'b0; wait_cyc(1);
        chk("R12 reset clears gates", int'(gate), 0);
        chk("R12 reset clears diag", int'(diag), 0);
        rst_n = 1'b1; wait_cyc(SET + TON + TDG + 3);
        chk("R2 direct 1010 after reset", int'(gate), 4'b0101);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule